// File: doc/BRIEF.md
# 64-bit Compare-Match Timer

This block is a memory-mapped timer. It holds a free-running 64-bit up-counter and a 64-bit compare value. When the compare logic is armed and the count reaches or passes the compare value, the block latches an event flag. It can also assert an interrupt line while that flag stays set. In periodic mode each match moves the compare value forward by a programmed step, so events keep arriving without any further software writes.

Software reaches every register through a simple 32-bit word bus. Each access takes one cycle, and reads are combinational. Both 64-bit quantities are split into a low and a high word. The high count word is never latched or held, so software can detect a carry between its reads by reading high, low, high and retrying if the two high values differ. A count-enable input gates each increment, which acts as a divide-by-one tick.

Top module: `cmp_timer64`

## Requirements
- R1: After reset, every register reads zero and `irq` is low.
- R2: The counter increases by exactly one on each clock where control bit 0 (run) and `tick_en` are both high and neither count word is being written. In every other cycle with no count write, the counter holds its value.
- R3: A write to word offset 0x00 replaces count bits 31:0, and a write to 0x04 replaces count bits 63:32. The other half keeps its value, and no increment is applied in that cycle.
- R4: A carry out of the low count word reaches the high word on the same clock edge. A read of 0x04 returns the live high word, so it can differ between two reads that bracket a read of 0x00.
- R5: With control bit 1 (compare on) set, a cycle in which count >= compare (0x10 low, 0x14 high), when the previous cycle was not in that state, sets status bit 0 (offset 0x0C) on the next clock. A match that persists sets the flag only once.
- R6: When control bit 3 (auto-advance) is set, each new match adds the 32-bit step at 0x18 to the compare value on the next clock. This gives periodic events. A bus write to a compare word in the same cycle takes priority.
- R7: Writing 1 to status bit 0 clears the flag, and writing 0 leaves it unchanged. A new match in the same cycle wins over the clear.
- R8: `irq` is high exactly while status bit 0 and control bit 2 (interrupt on) are both set.
- R9: Control reads return only bits 3:0, with the upper bits zero, and status reads return only bit 0. Offsets 0x1C and above read zero, and writes to them change nothing. Address bits 1:0 are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the accessed word |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| tick_en | input | 1 | Count enable, one increment per high cycle |
| irq | output | 1 | Interrupt request, level |

## Verification
The embedded properties check the following on every cycle: that the counter steps by one or holds, that the carry reaches the high word, that a fresh match raises the flag, that a match in auto-advance mode moves the compare value by the step, that a write of 1 clears the flag, and that a cleared flag keeps `irq` low. Other behaviours can only be shown by the bench scenarios. These are the overall periodic schedule across several events, the precedence of a bus write over an increment or an advance, the single event per persistent match, the masking of `irq` by the interrupt-on bit, and the zero reads of reserved bits and unmapped offsets. The bench covers them with directed sequences and with a long random mix of writes and reads compared against a register-level model.

// File: rtl/cmp_timer64.sv
module cmp_timer64 #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              tick_en,
  output logic              irq
);
  localparam int IW = ADDR_W - 2;
  localparam logic [IW-1:0] I_CLO = IW'(0);
  localparam logic [IW-1:0] I_CHI = IW'(1);
  localparam logic [IW-1:0] I_CTL = IW'(2);
  localparam logic [IW-1:0] I_STS = IW'(3);
  localparam logic [IW-1:0] I_MLO = IW'(4);
  localparam logic [IW-1:0] I_MHI = IW'(5);
  localparam logic [IW-1:0] I_PER = IW'(6);

  logic [63:0] cnt, cmp;
  logic [31:0] per;
  logic        run, cmp_on, ien, auto;
  logic        flag, match_d;

  wire [IW-1:0] widx = bus_addr[ADDR_W-1:2];
  wire wr_clo = bus_we && widx == I_CLO;
  wire wr_chi = bus_we && widx == I_CHI;
  wire wr_ctl = bus_we && widx == I_CTL;
  wire wr_sts = bus_we && widx == I_STS;
  wire wr_mlo = bus_we && widx == I_MLO;
  wire wr_mhi = bus_we && widx == I_MHI;
  wire wr_per = bus_we && widx == I_PER;

  wire step  = run && tick_en;
  wire match = cmp_on && (cnt >= cmp);
  wire hit   = match && !match_d;

  assign irq = flag && ien;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (wr_clo) begin
      cnt[31:0] <= bus_wdata;
    end else if (wr_chi) begin
      cnt[63:32] <= bus_wdata;
    end else if (step) begin
      cnt <= cnt + 64'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp <= '0;
    end else if (wr_mlo) begin
      cmp[31:0] <= bus_wdata;
    end else if (wr_mhi) begin
      cmp[63:32] <= bus_wdata;
    end else if (hit && auto) begin
      cmp <= cmp + {32'd0, per};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {auto, ien, cmp_on, run} <= '0;
      per     <= '0;
      flag    <= 1'b0;
      match_d <= 1'b0;
    end else begin
      if (wr_ctl) {auto, ien, cmp_on, run} <= bus_wdata[3:0];
      if (wr_per) per <= bus_wdata;
      if (hit) flag <= 1'b1;
      else if (wr_sts && bus_wdata[0]) flag <= 1'b0;
      match_d <= match;
    end
  end

  always_comb begin
    case (widx)
      I_CLO:   bus_rdata = cnt[31:0];
      I_CHI:   bus_rdata = cnt[63:32];
      I_CTL:   bus_rdata = {28'd0, auto, ien, cmp_on, run};
      I_STS:   bus_rdata = {31'd0, flag};
      I_MLO:   bus_rdata = cmp[31:0];
      I_MHI:   bus_rdata = cmp[63:32];
      I_PER:   bus_rdata = per;
      default: bus_rdata = '0;
    endcase
  end

  p_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
    step && !wr_clo && !wr_chi |=> cnt == $past(cnt) + 64'd1);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !step && !wr_clo && !wr_chi |=> $stable(cnt));

  p_carry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    step && !wr_clo && !wr_chi && cnt[31:0] == 32'hFFFF_FFFF
    |=> cnt[31:0] == 32'd0 && cnt[63:32] == $past(cnt[63:32]) + 32'd1);

  p_flag_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> flag);

  p_advance_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hit && auto && !wr_mlo && !wr_mhi |=> cmp == $past(cmp) + {32'd0, $past(per)});

  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !hit && wr_sts && bus_wdata[0] |=> !flag && !irq);

  p_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !flag |-> !irq);
endmodule

// File: tb/cmp_timer64_bench.sv
module cmp_timer64_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tick_en = 1'b0;
  logic        irq;

  int vectors = 0;
  int misses = 0;
  bit done = 1'b0;

  logic [63:0] m_cnt = '0, m_cmp = '0;
  logic [31:0] m_per = '0;
  logic [3:0]  m_ctl = '0;
  logic        m_flag = 1'b0, m_md = 1'b0;

  always #4 clk = ~clk;

  cmp_timer64 #(.ADDR_W(6)) u_cmp_timer64 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_en(tick_en), .irq(irq)
  );

  function automatic logic [31:0] m_read(input logic [5:0] a);
    case (a[5:2])
      4'd0: return m_cnt[31:0];
      4'd1: return m_cnt[63:32];
      4'd2: return {28'd0, m_ctl};
      4'd3: return {31'd0, m_flag};
      4'd4: return m_cmp[31:0];
      4'd5: return m_cmp[63:32];
      4'd6: return m_per;
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag_of(input logic [5:0] a);
    case (a[5:2])
      4'd0, 4'd1: return "R2";
      4'd3: return "R5";
      4'd4, 4'd5, 4'd6: return "R6";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic m_step(input logic [5:0] a, input logic we, input logic [31:0] wd, input logic te);
    logic match, hit;
    match = m_ctl[1] && (m_cnt >= m_cmp);
    hit = match && !m_md;
    if (we && a[5:2] == 4'd0) m_cnt[31:0] = wd;
    else if (we && a[5:2] == 4'd1) m_cnt[63:32] = wd;
    else if (m_ctl[0] && te) m_cnt = m_cnt + 64'd1;
    if (we && a[5:2] == 4'd4) m_cmp[31:0] = wd;
    else if (we && a[5:2] == 4'd5) m_cmp[63:32] = wd;
    else if (hit && m_ctl[3]) m_cmp = m_cmp + {32'd0, m_per};
    if (hit) m_flag = 1'b1;
    else if (we && a[5:2] == 4'd3 && wd[0]) m_flag = 1'b0;
    if (we && a[5:2] == 4'd2) m_ctl = wd[3:0];
    if (we && a[5:2] == 4'd6) m_per = wd;
    m_md = match;
  endtask

  // one bus cycle: drive at negedge, compare against model, then advance model
  task automatic cyc(input logic [5:0] a, input logic we, input logic [31:0] wd, input logic te);
    bus_addr = a; bus_we = we; bus_wdata = wd; tick_en = te;
    #1;
    check(tag_of(a), bus_rdata, m_read(a));
    check("R8", {31'd0, irq}, {31'd0, m_flag && m_ctl[2]});
    @(posedge clk);
    m_step(a, we, wd, te);
    @(negedge clk);
  endtask

  task automatic expect_rd(input string req, input logic [5:0] a, input logic [31:0] exp);
    bus_addr = a; bus_we = 1'b0; tick_en = 1'b0;
    #1;
    check(req, bus_rdata, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      misses++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2741));
    repeat (3) @(negedge clk);
    // R1: reset values
    for (int i = 0; i < 8; i++) expect_rd("R1", 6'(i * 4), 32'd0);
    check("R1", {31'd0, irq}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R4: carry into the high word, high word live
    cyc(6'h00, 1'b1, 32'hFFFF_FFFE, 1'b1);
    cyc(6'h04, 1'b1, 32'd5, 1'b1);
    cyc(6'h08, 1'b1, 32'd1, 1'b0);
    cyc(6'h00, 1'b0, 32'd0, 1'b1);
    cyc(6'h04, 1'b0, 32'd0, 1'b1);
    expect_rd("R4", 6'h04, 32'd6);
    expect_rd("R4", 6'h00, 32'd0);

    // R6: periodic events, compare starts at 10 with step 7
    cyc(6'h08, 1'b1, 32'd0, 1'b0);
    cyc(6'h00, 1'b1, 32'd0, 1'b0);
    cyc(6'h04, 1'b1, 32'd0, 1'b0);
    cyc(6'h10, 1'b1, 32'd10, 1'b0);
    cyc(6'h18, 1'b1, 32'd7, 1'b0);
    cyc(6'h0C, 1'b1, 32'd1, 1'b0);
    cyc(6'h08, 1'b1, 32'hFFFF_FF0F, 1'b0);
    for (int i = 0; i < 30; i++) cyc(6'h0C, 1'b0, 32'd0, 1'b1);
    expect_rd("R6", 6'h10, 32'd31);
    expect_rd("R9", 6'h08, 32'hF);
    expect_rd("R5", 6'h0C, 32'd1);

    // R7: writing 0 keeps the flag, writing 1 clears it
    cyc(6'h0C, 1'b1, 32'hFFFF_FFFE, 1'b0);
    expect_rd("R7", 6'h0C, 32'd1);
    cyc(6'h0C, 1'b1, 32'd1, 1'b0);
    expect_rd("R7", 6'h0C, 32'd0);
    check("R7", {31'd0, irq}, 32'd0);

    // R8: flag without interrupt-on keeps irq low
    cyc(6'h08, 1'b1, 32'hB, 1'b0);
    cyc(6'h0C, 1'b0, 32'd0, 1'b1);
    cyc(6'h0C, 1'b0, 32'd0, 1'b0);
    expect_rd("R8", 6'h0C, 32'd1);
    check("R8", {31'd0, irq}, 32'd0);
    cyc(6'h08, 1'b1, 32'hF, 1'b0);
    #1 check("R8", {31'd0, irq}, 32'd1);

    // R9: unmapped offsets
    cyc(6'h20, 1'b1, 32'hDEAD_BEEF, 1'b0);
    cyc(6'h1C, 1'b1, 32'h1234_5678, 1'b0);
    expect_rd("R9", 6'h20, 32'd0);
    expect_rd("R9", 6'h1C, 32'd0);
    expect_rd("R9", 6'h11, 32'd38);

    // random mix, checked against the model every cycle (R2, R3, R5, R6)
    for (int n = 0; n < 20000; n++) begin
      logic [5:0]  a;
      logic [31:0] wd;
      logic        we, te;
      te = ($urandom % 4) != 0;
      a  = 6'(($urandom % 16) * 4);
      we = ($urandom % 100) >= 60;
      wd = $urandom;
      if (we) begin
        a = 6'(($urandom % 8) * 4);
        case (a[5:2])
          4'd0, 4'd4: wd = $urandom % 300;
          4'd1, 4'd5: wd = (($urandom % 16) == 0) ? 32'd1 : 32'd0;
          4'd2: wd[0] = ($urandom % 5) != 0;
          4'd6: wd = $urandom % 16;
          default: ;
        endcase
      end
      cyc(a, we, wd, te);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule